// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block is the memory side of a small 8-bit processor system with a 16-bit address bus. The two most significant address bits pick one of four 16 KB regions. Each region is set at elaboration time to hold a read-only device, a read/write device, or nothing. The block contains the storage itself. It returns read data and reports on a one-hot output which region the current access falls in. The bus strobes are active low: a memory request, a read and a write.

Each device is smaller than its region, 256 bytes by default. With partial decoding on, the region address bits above the device ignore the device's upper address lines. The device then appears again at every device-sized step through its region. With partial decoding off, only the lowest device-sized window of the region responds, and the rest of the region behaves as unmapped. The read-only contents are computed from the address, so the block needs no image file. The default map puts the read-only device in the lowest region and read/write devices in the other three.

The bus is a plain strobe bus with no back-pressure. Every access completes in the cycle it is presented, so there is no valid/ready handshake.

Top module: `bank_mem_decoder`

## Requirements
- R1: `region_sel` is one-hot with bit `addr[15:14]` set while `mreq_n` is low and `rd_n` or `wr_n` is low. In every other case `region_sel` is 4'b0000, including when `rd_n` is low but `mreq_n` is high. The region is reported whatever it is configured as.
- R2: `rdata` is FFh whenever no read is active, meaning `mreq_n` or `rd_n` is high. This includes cycles that carry only a write.
- R3: A read from the read-only region (0000h–3FFFh in the default map) returns, in the same cycle, the low address byte XOR A5h.
- R4: A write to the read-only region leaves its contents unchanged.
- R5: A write to a read/write region takes effect on the rising clock edge while `mreq_n` and `wr_n` are low. A later read of the same address returns the written byte combinationally.
- R6: A read from an unmapped region returns FFh. A write to it stores nothing and does not disturb any other region.
- R7: With partial decoding, a device of 2^8 bytes answers at every 100h step through its region. For example, 4044h, 5A44h and 7F44h all reach the same byte.
- R8: With full decoding, only offsets 0000h–00FFh of a region reach the device. Other offsets read FFh, and writes to them do not change the device.
- R9: No write takes effect while `rst_n` is low. Reset does not clear stored data.
- R10: The read/write regions are independent: the same offset written in two regions holds two separate values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rdata | output | 8 | Read data, FFh when no read hits a device |
| region_sel | output | 4 | One-hot region of the qualified access |

## Verification
A wrong decode shows at once on `region_sel` and `rdata`, because both are combinational on the address and strobes within the cycle. A corrupted or misdirected write stays hidden until the affected location is read back. The bench therefore follows each write with reads of the target, of its mirrors, and of the same offset in neighbouring regions. Two instances are driven with the same stimulus, one partially decoded and one fully decoded with an unmapped region. Any aliasing error then appears as a value mismatch on the very next read, rather than only as a corrupted location.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  // Region kind codes, two bits per region in the map parameter
  typedef enum logic [1:0] {
    KIND_EMPTY = 2'd0,
    KIND_ROM   = 2'd1,
    KIND_RAM   = 2'd2
  } region_kind_e;

  // Qualified access strobes after the memory-request gate
  typedef struct packed {
    logic rd_act;
    logic wr_act;
  } strobe_t;

endpackage

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
  import bmd_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int REGION_BITS    = 2,
  parameter int DEV_AW         = 8,
  parameter bit PARTIAL_DECODE = 1'b1,
  localparam int NUM_REGIONS   = 1 << REGION_BITS,
  localparam int REG_AW        = ADDR_W - REGION_BITS
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   mreq_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  output strobe_t                strb,
  output logic [NUM_REGIONS-1:0] sel,
  output logic [REGION_BITS-1:0] region_idx,
  output logic [DEV_AW-1:0]      dev_off,
  output logic                   dev_hit
);

  logic [REG_AW-DEV_AW-1:0] upper_off;

  always_comb begin
    strb.rd_act = !mreq_n && !rd_n;
    strb.wr_act = !mreq_n && !wr_n;
    region_idx  = addr[ADDR_W-1 -: REGION_BITS];
    dev_off     = addr[DEV_AW-1:0];
    upper_off   = addr[REG_AW-1:DEV_AW];
    // Partial decoding ignores the bits between device and region size
    dev_hit     = PARTIAL_DECODE || (upper_off == '0);
    sel         = (strb.rd_act || strb.wr_act) ? (NUM_REGIONS'(1) << region_idx)
                                               : '0;
  end

endmodule

// File: rtl/bmd_ram_bank.sv
module bmd_ram_bank #(
  parameter int DATA_W = 8,
  parameter int DEV_AW = 8,
  localparam int DEPTH = 1 << DEV_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DEV_AW-1:0] off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[off] <= wdata;
  end

  assign rdata = cells[off];

endmodule

// File: rtl/bmd_rom_pattern.sv
module bmd_rom_pattern #(
  parameter int DATA_W            = 8,
  parameter int DEV_AW            = 8,
  parameter logic [DATA_W-1:0] SEED = 8'hA5
) (
  input  logic [DEV_AW-1:0] off,
  output logic [DATA_W-1:0] rdata
);

  // Contents are a function of the offset, so no image is loaded
  assign rdata = DATA_W'(off) ^ SEED;

endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import bmd_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int REGION_BITS    = 2,
  parameter int DEV_AW         = 8,
  parameter bit PARTIAL_DECODE = 1'b1,
  parameter logic [2*(1<<REGION_BITS)-1:0] REGION_MAP = 8'hA9,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'hA5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        mreq_n,
  input  logic                        rd_n,
  input  logic                        wr_n,
  output logic [DATA_W-1:0]           rdata,
  output logic [(1<<REGION_BITS)-1:0] region_sel
);

  localparam int NUM_REGIONS        = 1 << REGION_BITS;
  localparam logic [DATA_W-1:0] FILL = '1;

  strobe_t                strb;
  logic [NUM_REGIONS-1:0] sel;
  logic [REGION_BITS-1:0] region_idx;
  logic [DEV_AW-1:0]      dev_off;
  logic                   dev_hit;
  logic [DATA_W-1:0]      region_data [NUM_REGIONS];

  bmd_region_decode #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS),
    .DEV_AW(DEV_AW), .PARTIAL_DECODE(PARTIAL_DECODE)
  ) decode_i (
    .addr(addr), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .strb(strb), .sel(sel), .region_idx(region_idx),
    .dev_off(dev_off), .dev_hit(dev_hit)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam logic [1:0] KIND = REGION_MAP[2*r +: 2];
    if (KIND == 2'(KIND_RAM)) begin : g_ram
      logic we;
      assign we = rst_n && strb.wr_act && sel[r] && dev_hit;
      bmd_ram_bank #(.DATA_W(DATA_W), .DEV_AW(DEV_AW)) bank_i (
        .clk(clk), .we(we), .off(dev_off), .wdata(wdata),
        .rdata(region_data[r])
      );
    end else if (KIND == 2'(KIND_ROM)) begin : g_rom
      bmd_rom_pattern #(.DATA_W(DATA_W), .DEV_AW(DEV_AW), .SEED(ROM_SEED)) rom_i (
        .off(dev_off), .rdata(region_data[r])
      );
    end else begin : g_empty
      assign region_data[r] = FILL;
    end
  end

  assign rdata      = (strb.rd_act && dev_hit) ? region_data[region_idx] : FILL;
  assign region_sel = sel;

endmodule

// File: rtl/bank_mem_decoder_chk.sv
module bank_mem_decoder_chk
  import bmd_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int REGION_BITS    = 2,
  parameter int DEV_AW         = 8,
  parameter bit PARTIAL_DECODE = 1'b1,
  parameter logic [2*(1<<REGION_BITS)-1:0] REGION_MAP = 8'hA9,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'hA5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wdata,
  input logic                        mreq_n,
  input logic                        rd_n,
  input logic                        wr_n,
  input logic [DATA_W-1:0]           rdata,
  input logic [(1<<REGION_BITS)-1:0] region_sel
);

  localparam int REG_AW = ADDR_W - REGION_BITS;

  logic [1:0] kind_now;
  logic       hit_now;
  assign kind_now = REGION_MAP[2*addr[ADDR_W-1 -: REGION_BITS] +: 2];
  assign hit_now  = PARTIAL_DECODE || (addr[REG_AW-1:DEV_AW] == '0);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel)); // R1
  AST_SEL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || (rd_n && wr_n)) |-> region_sel == '0); // R1
  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && (!rd_n || !wr_n)) |-> region_sel[addr[ADDR_W-1 -: REGION_BITS]]); // R1
  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || rd_n) |-> rdata == '1); // R2
  AST_ROM_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !rd_n && kind_now == 2'(KIND_ROM) && hit_now)
      |-> rdata == (DATA_W'(addr[DEV_AW-1:0]) ^ ROM_SEED)); // R3
  AST_EMPTY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !rd_n && (kind_now != 2'(KIND_ROM)) && (kind_now != 2'(KIND_RAM)))
      |-> rdata == '1); // R6
  AST_FULL_MISS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !rd_n && !hit_now) |-> rdata == '1); // R8
  AST_RAM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !wr_n && kind_now == 2'(KIND_RAM) && hit_now)
      |=> (mreq_n || rd_n || addr != $past(addr) || rdata == $past(wdata))); // R5

endmodule

bind bank_mem_decoder bank_mem_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_BITS(REGION_BITS),
  .DEV_AW(DEV_AW), .PARTIAL_DECODE(PARTIAL_DECODE),
  .REGION_MAP(REGION_MAP), .ROM_SEED(ROM_SEED)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mreq_n(mreq_n),
  .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .region_sel(region_sel)
);

// File: tb/bank_mem_decoder_tb_top.sv
module bank_mem_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  rdata_p, rdata_f;
  logic [3:0]  sel_p, sel_f;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  // Partially decoded, default map
  bank_mem_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mreq_n(mreq_n),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata_p), .region_sel(sel_p)
  );

  // Fully decoded, region 2 unmapped: map 10_00_10_01
  bank_mem_decoder #(.PARTIAL_DECODE(1'b0), .REGION_MAP(8'h89)) dut_full_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mreq_n(mreq_n),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata_f), .region_sel(sel_f)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Drive strobes for part of a low clock phase, sample, then go idle
  task automatic drive_sample(logic [15:0] a, logic mq, logic rd, logic wr);
    @(negedge clk);
    addr = a; mreq_n = mq; rd_n = rd; wr_n = wr;
    #2;
  endtask

  task automatic go_idle();
    mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(logic [15:0] a);
    drive_sample(a, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; mreq_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    go_idle();
  endtask

  task automatic t_reset_state();
    #1;
    check("R2 reset idle rdata", rdata_p, 8'hFF);
    check("R1 reset idle sel", {4'h0, sel_p}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_region_select();
    for (int r = 0; r < 4; r++) begin
      bus_read({r[1:0], 14'h0123});
      check("R1 sel on read", {4'h0, sel_p}, 8'(1 << r));
      check("R1 sel on read full", {4'h0, sel_f}, 8'(1 << r));
      go_idle();
    end
    drive_sample(16'h8123, 1'b1, 1'b0, 1'b1);
    check("R1 no mreq sel", {4'h0, sel_p}, 8'h00);
    check("R2 no mreq rdata", rdata_p, 8'hFF);
    go_idle();
    drive_sample(16'hC010, 1'b0, 1'b1, 1'b1);
    check("R1 no strobe sel", {4'h0, sel_p}, 8'h00);
    go_idle();
  endtask

  task automatic t_rom_read();
    bus_read(16'h0000); check("R3 rom 0000", rdata_p, 8'hA5); go_idle();
    bus_read(16'h00FF); check("R3 rom 00FF", rdata_p, 8'h5A); go_idle();
    bus_read(16'h3F3C); check("R3 rom 3F3C", rdata_p, 8'h99); go_idle();
    bus_read(16'h1234); check("R3 rom 1234", rdata_f, 8'hFF); go_idle();
    bus_read(16'h1234); check("R3 rom 1234 partial", rdata_p, 8'h91); go_idle();
  endtask

  task automatic t_rom_write();
    bus_write(16'h0010, 8'h00);
    bus_read(16'h0010); check("R4 rom after write", rdata_p, 8'hB5); go_idle();
  endtask

  task automatic t_ram_rw();
    // rdata during a write-only cycle
    drive_sample(16'h4001, 1'b0, 1'b1, 1'b0);
    check("R2 write-only rdata", rdata_p, 8'hFF);
    go_idle();
    bus_write(16'h4001, 8'h5A);
    bus_write(16'h8002, 8'h3C);
    bus_write(16'hC0FF, 8'hE7);
    bus_read(16'h4001); check("R5 ram 4001", rdata_p, 8'h5A); go_idle();
    bus_read(16'h8002); check("R5 ram 8002", rdata_p, 8'h3C); go_idle();
    bus_read(16'hC0FF); check("R5 ram C0FF", rdata_p, 8'hE7); go_idle();
    bus_read(16'hC0FF); check("R5 ram C0FF full", rdata_f, 8'hE7); go_idle();
  endtask

  task automatic t_independent();
    bus_write(16'h4033, 8'h11);
    bus_write(16'h8033, 8'h22);
    bus_write(16'hC033, 8'h33);
    bus_read(16'h4033); check("R10 region1", rdata_p, 8'h11); go_idle();
    bus_read(16'h8033); check("R10 region2", rdata_p, 8'h22); go_idle();
    bus_read(16'hC033); check("R10 region3", rdata_p, 8'h33); go_idle();
  endtask

  task automatic t_mirror();
    bus_write(16'h4044, 8'hAB);
    bus_read(16'h4144); check("R7 mirror 4144", rdata_p, 8'hAB); go_idle();
    bus_read(16'h5A44); check("R7 mirror 5A44", rdata_p, 8'hAB); go_idle();
    bus_read(16'h7F44); check("R7 mirror 7F44", rdata_p, 8'hAB); go_idle();
    bus_read(16'h3F00); check("R7 rom mirror 3F00", rdata_p, 8'hA5); go_idle();
  endtask

  task automatic t_full_decode();
    bus_write(16'h4050, 8'h3C);
    bus_write(16'h4150, 8'hC3);
    bus_read(16'h4150); check("R8 full miss read", rdata_f, 8'hFF); go_idle();
    bus_read(16'h4050); check("R8 full device kept", rdata_f, 8'h3C); go_idle();
    bus_read(16'h4050); check("R7 partial aliased", rdata_p, 8'hC3); go_idle();
  endtask

  task automatic t_empty();
    bus_write(16'h4005, 8'h11);
    bus_write(16'h8005, 8'h77);
    bus_read(16'h8005);
    check("R6 empty read", rdata_f, 8'hFF);
    check("R1 empty region reported", {4'h0, sel_f}, 8'h04);
    check("R6 same addr mapped", rdata_p, 8'h77);
    go_idle();
    bus_read(16'h4005); check("R6 other region intact", rdata_f, 8'h11); go_idle();
  endtask

  task automatic t_reset_write();
    bus_write(16'h4060, 8'h42);
    @(negedge clk); rst_n = 1'b0;
    bus_write(16'h4060, 8'h99);
    @(negedge clk); rst_n = 1'b1;
    bus_read(16'h4060);
    check("R9 write in reset blocked", rdata_p, 8'h42);
    check("R9 write in reset blocked full", rdata_f, 8'h42);
    go_idle();
  endtask

  initial begin
    t_reset_state();
    t_region_select();
    t_rom_read();
    t_rom_write();
    t_ram_rw();
    t_independent();
    t_mirror();
    t_full_decode();
    t_empty();
    t_reset_write();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule